// File: doc/BRIEF.md
# Add/Subtract Unit with Overflow and True-Sign Flags

This block is a purely combinational two-operand integer adder/subtractor of parameterized width. A mode input selects addition or subtraction. For subtraction the second operand is bitwise inverted and a carry of one enters the low end of the chain. The block returns one result word, which is valid under both the unsigned and the two's-complement reading of the operands.

Three status flags go with the result:
- An unsigned overflow flag.
- A signed overflow flag.
- A true-sign flag. It gives the sign of the exact result, as if the result had unlimited width, so a comparator or a sequential signed multiplier can rely on it even when the signed result wraps.

The carry chain is a plain ripple structure. No clock is involved.

Top module: `addsub_flags`

## Requirements
- R1: `res` equals `(a + b) mod 2^W` when `sub` is 0 and `(a - b) mod 2^W` when `sub` is 1. The same bits serve both the unsigned and the signed reading.
- R2: With `sub` = 0, `ovf_u` is 1 exactly when the unsigned sum of `a` and `b` exceeds 2^W - 1. In carry terms, this is when the chain produces a carry out of the top bit.
- R3: With `sub` = 1, `ovf_u` is 1 exactly when `a` < `b` read as unsigned numbers. In carry terms, this is when the chain produces no carry out of the top bit.
- R4: `ovf_s` is 1 exactly when the exact signed result of the selected operation lies outside [-2^(W-1), 2^(W-1) - 1]. This holds in both modes.
- R5: `sign_true` is 1 exactly when the exact signed result is negative. This holds even when `ovf_s` is 1.
- R6: When `ovf_s` is 0, `sign_true` equals `res[W-1]`. When `ovf_s` is 1, `sign_true` is the inverse of `res[W-1]`.
- R7: For W = 4, the following cases hold:
  - 1010 + 0110 gives 0000 with `ovf_u` = 1.
  - 0111 - 1010 gives 1101 with `ovf_u` = 1.
  - 0110 + 0111 gives 1101 with `ovf_s` = 1 and `sign_true` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand; subtracted from `a` when `sub` is 1 |
| sub | input | 1 | Mode: 0 selects add, 1 selects subtract |
| res | output | W | Sum or difference, modulo 2^W |
| ovf_u | output | 1 | Unsigned overflow or borrow |
| ovf_s | output | 1 | Two's-complement overflow |
| sign_true | output | 1 | Sign of the exact, unwrapped signed result |

## Verification
The bench sweeps every operand pair in both modes at width 4. It then drives wrap-around extremes at width 8: the most negative value minus one, the largest positive value plus one, zero minus zero, and all-ones plus one.

These cases expose the following errors:
- A design that ignores the mode when forming the unsigned flag reports a carry where a borrow is meant. Zero minus zero would then falsely flag overflow.
- A design that takes the true sign from the pre-inversion `b` gives the wrong sign on signed-overflowing subtractions.
- A design that feeds a wrong carry pair into the signed-overflow XOR misses positive plus positive wrapping to negative.
- Mixed-sign pairs catch a design that reports the raw result MSB as the true sign.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         ovf_u,
  output logic         ovf_s,
  output logic         sign_true
);

  logic [W-1:0] bx;
  logic [W:0]   cy;

  assign bx    = b ^ {W{sub}};
  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p         = a[i] ^ bx[i];
    assign res[i]    = p ^ cy[i];
    assign cy[i+1]   = (a[i] & bx[i]) | (p & cy[i]);
  end

  assign ovf_u     = cy[W] ^ sub;
  assign ovf_s     = cy[W] ^ cy[W-1];
  assign sign_true = a[W-1] ^ bx[W-1] ^ cy[W];

endmodule

module addsub_flags_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         sub,
  input logic [W-1:0] res,
  input logic         ovf_u,
  input logic         ovf_s,
  input logic         sign_true
);

  logic [W:0]        wu;
  logic signed [W:0] ws;

  assign wu = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
  assign ws = sub ? ($signed({a[W-1], a}) - $signed({b[W-1], b}))
                  : ($signed({a[W-1], a}) + $signed({b[W-1], b}));

  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      a_r1_result: assert (res == wu[W-1:0]);
      if (!sub) a_r2_add_carry: assert (ovf_u == wu[W]);
      if (sub)  a_r3_sub_borrow: assert (ovf_u == wu[W]);
      a_r4_signed_range: assert (ovf_s == (ws[W] != ws[W-1]));
      a_r5_true_sign: assert (sign_true == ws[W]);
      a_r6_sign_vs_msb: assert (sign_true == (res[W-1] ^ ovf_s));
    end
  end

endmodule

bind addsub_flags addsub_flags_chk #(.W(W)) u_chk (.*);

// File: tb/addsub_flags_bench.sv
module addsub_flags_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] a8, b8, r8;
  logic       s8, u8, o8, t8;
  logic [3:0] a4, b4, r4;
  logic       s4, u4, o4, t4;

  addsub_flags #(.W(8)) u_addsub_flags (
    .a(a8), .b(b8), .sub(s8), .res(r8), .ovf_u(u8), .ovf_s(o8), .sign_true(t8)
  );
  addsub_flags #(.W(4)) u_addsub_flags_w4 (
    .a(a4), .b(b4), .sub(s4), .res(r4), .ovf_u(u4), .ovf_s(o4), .sign_true(t4)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(int n, int ai, int bi, bit sb);
    int m, sa, sbv, wu, ws, er, eu, es, et;
    m   = 1 << n;
    sa  = (ai >= m/2) ? ai - m : ai;
    sbv = (bi >= m/2) ? bi - m : bi;
    wu  = sb ? ai - bi : ai + bi;
    ws  = sb ? sa - sbv : sa + sbv;
    er  = ((wu % m) + m) % m;
    eu  = sb ? int'(ai < bi) : int'(wu >= m);
    es  = int'(ws >= m/2 || ws < -(m/2));
    et  = int'(ws < 0);
    @(posedge clk); #1;
    if (n == 4) begin a4 = 4'(ai); b4 = 4'(bi); s4 = sb; end
    else        begin a8 = 8'(ai); b8 = 8'(bi); s8 = sb; end
    @(negedge clk);
    if (n == 4) begin
      chk("R1 res w4", int'(r4), er);
      chk(sb ? "R3 ovf_u w4" : "R2 ovf_u w4", int'(u4), eu);
      chk("R4 ovf_s w4", int'(o4), es);
      chk("R5 sign_true w4", int'(t4), et);
      chk("R6 sign vs msb w4", int'(t4), int'(r4[3]) ^ es);
    end else begin
      chk("R1 res w8", int'(r8), er);
      chk(sb ? "R3 ovf_u w8" : "R2 ovf_u w8", int'(u8), eu);
      chk("R4 ovf_s w8", int'(o8), es);
      chk("R5 sign_true w8", int'(t8), et);
      chk("R6 sign vs msb w8", int'(t8), int'(r8[7]) ^ es);
    end
  endtask

  initial begin
    a8 = '0; b8 = '0; s8 = 1'b0; a4 = '0; b4 = '0; s4 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 idle res zero", int'(r8), 0);
    chk("R2 idle ovf_u zero", int'(u8), 0);

    // R7: worked 4-bit cases
    run(4, 10, 6, 1'b0);
    chk("R7 1010+0110 res", int'(r4), 0);
    chk("R7 1010+0110 ovf_u", int'(u4), 1);
    run(4, 7, 10, 1'b1);
    chk("R7 0111-1010 res", int'(r4), 13);
    chk("R7 0111-1010 ovf_u", int'(u4), 1);
    run(4, 6, 7, 1'b0);
    chk("R7 0110+0111 res", int'(r4), 13);
    chk("R7 0110+0111 ovf_s", int'(o4), 1);
    chk("R7 0110+0111 sign_true", int'(t4), 0);

    for (int sb = 0; sb < 2; sb++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          run(4, x, y, sb[0]);

    run(8, 128, 1, 1'b1);
    run(8, 127, 1, 1'b0);
    run(8, 0, 0, 1'b1);
    run(8, 255, 1, 1'b0);
    run(8, 128, 128, 1'b0);
    run(8, 127, 128, 1'b1);
    run(8, 0, 128, 1'b1);
    run(8, 255, 255, 1'b1);
    for (int k = 0; k < 1500; k++)
      run(8, int'($urandom_range(255)), int'($urandom_range(255)), 1'($urandom_range(1)));

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule